// File: doc/BRIEF.md
# Burst-of-Four Separate-Port DDR SRAM Model

This block is a synthesizable behavioural model of a static RAM with independent read and write data ports, each moving one data word per half clock, and a burst length of four words. A single address bus and two active-low selects (one for reads, one for writes) are sampled once per device clock. Each accepted operation transfers a four-word, burst-aligned line: the line address picks the line and the four beats map to words 0 to 3 of that line in order.

The double-rate beats are modelled on one fast clock that runs at twice the device clock. An internal half-cycle phase, exported on `half_phase`, marks which fast tick is the command slot (phase 0) and which is the second half (phase 1). Because a burst occupies two device clocks, a read cannot follow a read in the next cycle and a write cannot follow a write. Write data enters one device clock after its command, and read data leaves two device clocks after its command. A read of a line that a write has just been issued to returns the new words, taken from the capture buffer when the array has not yet been updated.

Top module: `qdr4_sram`

## Requirements
- R1: In a command slot that follows a deselect, `rd_sel_n` and `wr_sel_n` both high give a deselect: no read beats are produced and the array is left unchanged.
- R2: In a command slot that follows a deselect, a low `rd_sel_n` starts a read whatever `wr_sel_n` is. A low `wr_sel_n` with a high `rd_sel_n` starts a write.
- R3: In the command slot right after a read, `rd_sel_n` is ignored. A low `wr_sel_n` starts a write, and otherwise the cycle is a deselect.
- R4: In the command slot right after a write, `wr_sel_n` is ignored. A low `rd_sel_n` starts a read, and otherwise the cycle is a deselect.
- R5: `half_phase` is 0 in the first fast tick after reset and toggles on every fast tick. Selects and `line_addr` are taken only in phase-0 ticks, and the address only on slots that start an operation.
- R6: For a write issued in fast tick T (phase 0), `wr_data` during ticks T+2, T+3, T+4 and T+5 is stored into words 0, 1, 2 and 3 of the addressed line.
- R7: For a read issued in fast tick T, `rd_data` carries words 0, 1, 2 and 3 of the addressed line during ticks T+4 to T+7. Beat 0 always falls in a phase-0 tick.
- R8: `rd_valid` and `rd_drive` are high exactly during the four beats of each read burst. At all other times `rd_data` is zero.
- R9: A read returns the line as left by all writes issued in earlier slots. This holds even when the write data is still being captured, in which case the words come from the capture buffer. A read issued before a write to the same line returns the old words.
- R10: While `rst` is high, `rd_valid` and `rd_drive` are low, any burst in flight is dropped, and the next slot is treated as following a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Fast clock, twice the device clock rate; one data beat per tick |
| rst | input | 1 | Synchronous active-high reset |
| rd_sel_n | input | 1 | Active-low read select, sampled in phase-0 ticks |
| wr_sel_n | input | 1 | Active-low write select, sampled in phase-0 ticks |
| line_addr | input | ADDR_W | Burst-aligned line address, taken on slots that start an operation |
| wr_data | input | DATA_W | Write data, one word per fast tick |
| half_phase | output | 1 | 0 in the command-slot tick, 1 in the second half |
| rd_data | output | DATA_W | Read data, one word per fast tick; zero when not driving |
| rd_valid | output | 1 | High during each of the four read beats |
| rd_drive | output | 1 | Output enable of the read port; low means high-impedance |

## Verification
On every cycle, the embedded properties check that two reads and two writes are never accepted in adjacent slots. They also check that a read burst lasts four ticks, starts in a phase-0 tick and comes in whole pairs, that idle read data is zero, and that a write commits only after its first three words have been captured. Only the bench scenarios can show that the arbitration picks the right operation after each kind of previous cycle, and that the correct words reach the correct line. They also cover reads returning old or freshly written data at the right tick, junk on ignored selects and addresses having no effect, and a reset in the middle of a burst.

// File: rtl/qdr4_pkg.sv
package qdr4_pkg;

    localparam int BEATS  = 4;
    localparam int BEAT_W = $clog2(BEATS);

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Slot arbitration: the operation that ran in the previous slot
    // blocks its own kind, an idle slot gives reads the priority.
    function automatic op_e pick_op(op_e prev, logic rd_n, logic wr_n);
        op_e res;
        res = OP_IDLE;
        case (prev)
            OP_READ:  if (!wr_n) res = OP_WRITE;
            OP_WRITE: if (!rd_n) res = OP_READ;
            default: begin
                if (!rd_n)      res = OP_READ;
                else if (!wr_n) res = OP_WRITE;
            end
        endcase
        return res;
    endfunction

endpackage

// File: rtl/qdr4_arbiter.sv
module qdr4_arbiter
    import qdr4_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic slot,
    input  logic rd_sel_n,
    input  logic wr_sel_n,
    output op_e  op
);

    op_e prev_q;

    always_comb begin
        op = slot ? pick_op(prev_q, rd_sel_n, wr_sel_n) : OP_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= OP_IDLE;
        end else if (slot) begin
            prev_q <= op;
        end
    end

    // R3: a read is never accepted in the slot right after a read
    p_read_gap_r3: assert property (@(posedge clk) disable iff (rst)
        (op == OP_READ) |=> ##1 (op != OP_READ));

    // R4: a write is never accepted in the slot right after a write
    p_write_gap_r4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_WRITE) |=> ##1 (op != OP_WRITE));

endmodule

// File: rtl/qdr4_wr_capture.sv
module qdr4_wr_capture
    import qdr4_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 18
)(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          slot,
    input  logic                          start,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic                          commit,
    output logic [ADDR_W-1:0]             line,
    output logic [BEATS-1:0][DATA_W-1:0]  words,
    output logic [BEATS-1:0]              mask
);

    localparam logic [BEAT_W-1:0] LAST_IDX = BEAT_W'(BEATS - 1);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    cmd_t                         s1_q;
    logic                         active_q;
    logic [BEAT_W-1:0]            idx_q;
    logic [BEATS-1:0][DATA_W-1:0] hold_q;

    assign commit = active_q && (idx_q == LAST_IDX);

    // Last word goes straight from the pin into the array on commit.
    always_comb begin
        words            = hold_q;
        words[BEATS-1]   = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q     <= '0;
            active_q <= 1'b0;
            idx_q    <= '0;
            mask     <= '0;
            line     <= '0;
            hold_q   <= '0;
        end else begin
            if (slot) begin
                s1_q.valid <= start;
                s1_q.addr  <= addr;
            end
            if (slot && s1_q.valid) begin
                active_q  <= 1'b1;
                idx_q     <= BEAT_W'(1);
                line      <= s1_q.addr;
                hold_q[0] <= wdata;
                mask      <= BEATS'(1);
            end else if (active_q) begin
                hold_q[idx_q] <= wdata;
                if (idx_q == LAST_IDX) begin
                    active_q <= 1'b0;
                    idx_q    <= '0;
                    mask     <= '0;
                end else begin
                    mask[idx_q] <= 1'b1;
                    idx_q       <= idx_q + BEAT_W'(1);
                end
            end
        end
    end

    // R6: the array update happens only once all earlier words are held
    p_commit_mask_r6: assert property (@(posedge clk) disable iff (rst)
        commit |-> (mask == {1'b0, {(BEATS-1){1'b1}}}));

endmodule

// File: rtl/qdr4_rd_return.sv
module qdr4_rd_return
    import qdr4_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 18
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              slot,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] fetch_line,
    output logic [BEAT_W-1:0] fetch_word,
    input  logic [DATA_W-1:0] fetch_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic [BEAT_W-1:0] LAST_IDX = BEAT_W'(BEATS - 1);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    cmd_t              s1_q;
    cmd_t              s2_q;
    logic              active_q;
    logic [BEAT_W-1:0] idx_q;
    logic [ADDR_W-1:0] line_q;
    logic              launch;

    // Beat 0 is loaded at the end of the phase-1 tick one device
    // clock after the command, so it drives two clocks after it.
    assign launch     = !slot && s2_q.valid;
    assign fetch_line = launch ? s2_q.addr : line_q;
    assign fetch_word = launch ? '0 : idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q     <= '0;
            s2_q     <= '0;
            active_q <= 1'b0;
            idx_q    <= '0;
            line_q   <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            if (slot) begin
                s1_q.valid <= start;
                s1_q.addr  <= addr;
                s2_q       <= s1_q;
            end
            if (launch) begin
                line_q   <= s2_q.addr;
                idx_q    <= BEAT_W'(1);
                active_q <= 1'b1;
                rd_valid <= 1'b1;
                rd_data  <= fetch_data;
            end else if (active_q) begin
                rd_valid <= 1'b1;
                rd_data  <= fetch_data;
                if (idx_q == LAST_IDX) begin
                    active_q <= 1'b0;
                    idx_q    <= '0;
                end else begin
                    idx_q <= idx_q + BEAT_W'(1);
                end
            end else begin
                rd_valid <= 1'b0;
                rd_data  <= '0;
            end
        end
    end

    // R8: every burst that ends has lasted four beats
    p_burst_len_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_valid) |-> ($past(rd_valid, 4) && $past(rd_valid, 3)));

    // R7: the first beat of a burst lands in a command-slot tick
    p_burst_align_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid) |-> slot);

    // R8: read data is quiet between bursts
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (rd_data == '0));

endmodule

// File: rtl/qdr4_line_store.sv
module qdr4_line_store
    import qdr4_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 18
)(
    input  logic                          clk,
    input  logic                          commit,
    input  logic [ADDR_W-1:0]             wr_line,
    input  logic [BEATS-1:0][DATA_W-1:0]  wr_words,
    input  logic [BEATS-1:0]              wr_mask,
    input  logic [ADDR_W-1:0]             fetch_line,
    input  logic [BEAT_W-1:0]             fetch_word,
    output logic [DATA_W-1:0]             fetch_data
);

    localparam int WORDS = (1 << ADDR_W) * BEATS;

    logic [DATA_W-1:0] mem_q [WORDS];
    logic              hit;

    always_ff @(posedge clk) begin
        if (commit) begin
            for (int k = 0; k < BEATS; k++) begin
                mem_q[{wr_line, BEAT_W'(k)}] <= wr_words[k];
            end
        end
    end

    // Words already captured for a pending write override the array.
    assign hit = (wr_line == fetch_line) && wr_mask[fetch_word];

    always_comb begin
        if (hit) fetch_data = wr_words[fetch_word];
        else     fetch_data = mem_q[{fetch_line, fetch_word}];
    end

endmodule

// File: rtl/qdr4_sram.sv
module qdr4_sram
    import qdr4_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 18
)(
    input  logic              clk2x,
    input  logic              rst,
    input  logic              rd_sel_n,
    input  logic              wr_sel_n,
    input  logic [ADDR_W-1:0] line_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              half_phase,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_drive
);

    logic                         phase_q;
    logic                         slot;
    op_e                          op;
    logic                         wr_commit;
    logic [ADDR_W-1:0]            wr_line;
    logic [BEATS-1:0][DATA_W-1:0] wr_words;
    logic [BEATS-1:0]             wr_mask;
    logic [ADDR_W-1:0]            fetch_line;
    logic [BEAT_W-1:0]            fetch_word;
    logic [DATA_W-1:0]            fetch_data;

    always_ff @(posedge clk2x) begin
        if (rst) phase_q <= 1'b0;
        else     phase_q <= ~phase_q;
    end

    assign slot       = ~phase_q;
    assign half_phase = phase_q;

    qdr4_arbiter u_arb (
        .clk      (clk2x),
        .rst      (rst),
        .slot     (slot),
        .rd_sel_n (rd_sel_n),
        .wr_sel_n (wr_sel_n),
        .op       (op)
    );

    qdr4_wr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
        .clk    (clk2x),
        .rst    (rst),
        .slot   (slot),
        .start  (op == OP_WRITE),
        .addr   (line_addr),
        .wdata  (wr_data),
        .commit (wr_commit),
        .line   (wr_line),
        .words  (wr_words),
        .mask   (wr_mask)
    );

    qdr4_line_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk        (clk2x),
        .commit     (wr_commit),
        .wr_line    (wr_line),
        .wr_words   (wr_words),
        .wr_mask    (wr_mask),
        .fetch_line (fetch_line),
        .fetch_word (fetch_word),
        .fetch_data (fetch_data)
    );

    qdr4_rd_return #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk        (clk2x),
        .rst        (rst),
        .slot       (slot),
        .start      (op == OP_READ),
        .addr       (line_addr),
        .fetch_line (fetch_line),
        .fetch_word (fetch_word),
        .fetch_data (fetch_data),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    assign rd_drive = rd_valid;

    // R7: a beat in a command-slot tick is always followed by its pair
    p_pair_beats_r7: assert property (@(posedge clk2x) disable iff (rst)
        (rd_valid && slot) |=> rd_valid);

endmodule

// File: tb/tb_qdr4_sram.sv
module tb_qdr4_sram;

    localparam int AW = 4;
    localparam int DW = 18;

    logic          clk2x = 1'b0;
    logic          rst = 1'b1;
    logic          rd_sel_n = 1'b1;
    logic          wr_sel_n = 1'b1;
    logic [AW-1:0] line_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          half_phase;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic          rd_drive;

    qdr4_sram #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk2x      (clk2x),
        .rst        (rst),
        .rd_sel_n   (rd_sel_n),
        .wr_sel_n   (wr_sel_n),
        .line_addr  (line_addr),
        .wr_data    (wr_data),
        .half_phase (half_phase),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .rd_drive   (rd_drive)
    );

    always #2 clk2x = ~clk2x;

    int            errors = 0;
    int            checks = 0;
    int            tk = 0;
    int            mprev = 0;
    string         scen = "R10 reset";
    logic          exp_v  [16];
    logic [DW-1:0] exp_d  [16];
    logic [DW-1:0] wd_ring[16];
    logic [DW-1:0] mdl    [64];

    task automatic tally(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s / %s actual=%0h expected=%0h", scen, tag, act, exp);
        end
    endtask

    function automatic int nxt_op(input int prev, input logic rn, input logic wn);
        if (prev == 1) return (!wn) ? 2 : 0;
        if (prev == 2) return (!rn) ? 1 : 0;
        if (!rn) return 1;
        if (!wn) return 2;
        return 0;
    endfunction

    task automatic clear_rings();
        for (int i = 0; i < 16; i++) begin
            exp_v[i]   = 1'b0;
            exp_d[i]   = '0;
            wd_ring[i] = '0;
        end
    endtask

    // One fast tick: check outputs of this tick, then drive its inputs.
    task automatic step(input logic rn, input logic wn, input logic [AW-1:0] a);
        int s;
        @(negedge clk2x);
        s = tk % 16;
        tally("R5 phase", DW'(half_phase), DW'(tk % 2));
        tally("R8 valid", DW'(rd_valid), DW'(exp_v[s]));
        tally("R8 drive", DW'(rd_drive), DW'(exp_v[s]));
        if (exp_v[s]) tally("R7 data", rd_data, exp_d[s]);
        else          tally("R8 idle data", rd_data, '0);
        exp_v[s]   = 1'b0;
        wr_data    = wd_ring[s];
        wd_ring[s] = DW'(tk * 37 + 5);
        rd_sel_n   = rn;
        wr_sel_n   = wn;
        line_addr  = a;
        tk++;
    endtask

    // One device clock: a command slot, then a tick of junk selects.
    task automatic cyc(input logic rn, input logic wn, input logic [AW-1:0] a,
                       input logic [DW-1:0] seed);
        int op = nxt_op(mprev, rn, wn);
        if (op == 1) begin
            for (int k = 0; k < 4; k++) begin
                exp_v[(tk + 4 + k) % 16] = 1'b1;
                exp_d[(tk + 4 + k) % 16] = mdl[int'(a) * 4 + k];
            end
        end else if (op == 2) begin
            for (int k = 0; k < 4; k++) begin
                wd_ring[(tk + 2 + k) % 16] = seed + DW'(k);
                mdl[int'(a) * 4 + k]       = seed + DW'(k);
            end
        end
        mprev = op;
        step(rn, wn, a);
        step(1'b0, 1'b0, ~a);
    endtask

    task automatic do_reset();
        scen = "R10 reset";
        rst = 1'b1;
        rd_sel_n = 1'b0;
        wr_sel_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk2x);
            tally("R10 valid in reset", DW'(rd_valid), '0);
            tally("R10 drive in reset", DW'(rd_drive), '0);
            tally("R10 phase in reset", DW'(half_phase), '0);
        end
        clear_rings();
        mprev    = 0;
        rst      = 1'b0;
        rd_sel_n = 1'b1;
        wr_sel_n = 1'b1;
        tk       = 1;
        step(1'b1, 1'b1, '0);
    endtask

    task automatic t_fill();
        scen = "R6 fill and readback";
        for (int l = 0; l < 16; l++) begin
            cyc(1'b1, 1'b0, AW'(l), DW'(l * 16 + 'h100));
            cyc(1'b1, 1'b1, AW'(l + 3), '0);
        end
        for (int l = 0; l < 16; l++) begin
            cyc(1'b0, 1'b1, AW'(l), '0);
            cyc(1'b1, 1'b1, AW'(l + 5), '0);
        end
    endtask

    task automatic t_after_idle();
        scen = "R2 choice after deselect";
        cyc(1'b1, 1'b1, 4'd1, '0);
        cyc(1'b0, 1'b0, 4'd3, 'h3aa);
        cyc(1'b1, 1'b1, 4'd2, '0);
        cyc(1'b1, 1'b0, 4'd5, 'h1500);
        cyc(1'b1, 1'b1, 4'd2, '0);
        cyc(1'b0, 1'b1, 4'd5, '0);
        cyc(1'b1, 1'b1, 4'd2, '0);
    endtask

    task automatic t_after_read();
        scen = "R3 slot after read";
        cyc(1'b0, 1'b1, 4'd2, '0);
        cyc(1'b0, 1'b0, 4'd2, 'h2200);
        cyc(1'b1, 1'b1, 4'd0, '0);
        cyc(1'b0, 1'b1, 4'd6, '0);
        cyc(1'b0, 1'b1, 4'd7, '0);
        cyc(1'b1, 1'b1, 4'd0, '0);
        cyc(1'b0, 1'b1, 4'd2, '0);
        cyc(1'b1, 1'b1, 4'd0, '0);
    endtask

    task automatic t_after_write();
        scen = "R4 slot after write";
        cyc(1'b1, 1'b0, 4'd10, 'h3400);
        cyc(1'b1, 1'b0, 4'd10, 'h3500);
        cyc(1'b1, 1'b1, 4'd0, '0);
        cyc(1'b0, 1'b1, 4'd10, '0);
        cyc(1'b1, 1'b1, 4'd0, '0);
    endtask

    task automatic t_forward();
        scen = "R9 read right after write";
        cyc(1'b1, 1'b0, 4'd9, 'h3900);
        cyc(1'b0, 1'b0, 4'd9, '0);
        cyc(1'b1, 1'b0, 4'd9, 'h3a00);
        cyc(1'b0, 1'b1, 4'd9, '0);
        cyc(1'b1, 1'b1, 4'd0, '0);
    endtask

    task automatic t_deselect();
        scen = "R1 deselect with junk";
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, AW'(i * 5), DW'('h3f000 + i));
        scen = "R5 address only on start";
        cyc(1'b0, 1'b1, 4'd12, '0);
        cyc(1'b0, 1'b1, 4'd13, '0);
        cyc(1'b1, 1'b1, 4'd12, '0);
        cyc(1'b0, 1'b1, 4'd0, '0);
        cyc(1'b1, 1'b1, 4'd0, '0);
    endtask

    task automatic t_stream();
        scen = "R9 alternating stream";
        for (int i = 0; i < 12; i++) cyc(1'b0, 1'b0, AW'(4 + (i / 2) % 3), DW'('h2000 + i * 16));
        for (int i = 0; i < 3; i++) begin
            cyc(1'b0, 1'b1, AW'(4 + i), '0);
            cyc(1'b1, 1'b1, '0, '0);
        end
    endtask

    task automatic t_reset_midburst();
        scen = "R10 reset mid burst";
        cyc(1'b0, 1'b1, 4'd1, '0);
        cyc(1'b1, 1'b1, 4'd0, '0);
        do_reset();
        scen = "R10 after reset";
        cyc(1'b0, 1'b0, 4'd1, 'h777);
        cyc(1'b1, 1'b1, 4'd0, '0);
        cyc(1'b1, 1'b1, 4'd0, '0);
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        checks++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mdl[i] = '0;
        clear_rings();
        do_reset();
        t_fill();
        t_after_idle();
        t_after_read();
        t_after_write();
        t_forward();
        t_deselect();
        t_stream();
        t_reset_midburst();
        scen = "R8 drain";
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, '0, '0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule